// File: doc/BRIEF.md
# MDIO Clause 22 management controller

This block is a memory-mapped master for the two-wire management bus that connects a MAC-side chip to external PHYs. Software writes a single command word that holds the PHY address, register number, operation and (for a write) the data. That one write launches a complete Clause 22 frame on the MDC/MDIO pins. The same word, read back, shows a busy flag while the frame runs. After a read frame it shows the 16 bits captured from the PHY together with a valid flag.

MDC is derived from the system clock by a programmable divider and runs only while a frame is in flight. Completion of every frame raises a cause bit in a separate cause register. Software clears that bit by writing it as zero. A mask register decides whether the cause bit reaches the interrupt pin.

Top module: `mdio_ctrl`

## Requirements
- R1: After reset the command, cause and mask registers read 0, and `irq_o`, `mdc_o` and `mdio_oe_o` are 0.
- R2: A write to offset 0x00 while idle starts a frame. The command word fields are: bits 15:0 data, bits 20:16 PHY address, bits 25:21 register number, and bit 26 the operation (1 = read, 0 = write). The frame has exactly 64 MDC cycles, shifted MSB first: 32 ones, start 01, opcode 10 (read) or 01 (write), PHY address, register number, turnaround, 16 data bits. For a write the turnaround is 10 and the data is bits 15:0.
- R3: On a read, `mdio_oe_o` is 0 from the first turnaround bit through the last data bit. The 16 bits sampled on MDC rising edges appear in bits 15:0 of the command register, and bit 27 reads 1 once the frame ends.
- R4: Bit 28 of the command register reads 1 from the clock after the command write for exactly 128*CLK_HALF clock cycles, then reads 0.
- R5: A write to the command register while bit 28 is 1 is ignored: the fields keep their values and no further frame is sent.
- R6: A command that starts a frame clears bit 27.
- R7: MDC has a period of 2*CLK_HALF clock cycles and is low when idle. The MDIO output changes only as MDC falls.
- R8: The end of each frame sets bit 4 of the cause register at 0x7C. Writing a word with bit 4 = 0 clears it, and writing bit 4 = 1 leaves it unchanged. If frame completion and a clear fall in the same cycle, the bit ends set.
- R9: `irq_o` is 1 exactly when cause bit 4 and bit 4 of the mask register at 0x80 are both 1.
- R10: All other bits of the cause and mask registers, and bits 31:29 of the command register, read 0. Bits 27 and 28 of a written command word have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Register byte offset |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |
| irq_o | output | 1 | Completion interrupt |

## Verification
Frame completion, which sets the cause bit, and a software write that clears that bit can land on the same clock edge. The bench derives the completion edge from the 128*CLK_HALF busy length. It places a clear write of the cause register exactly on that edge, and afterwards expects the cause bit to read 1. It also clears the bit on a later cycle and expects 0. A second collision, a command write landing mid-frame, is judged by the fields read back and by the MDC rise count staying at 64.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int REG_W     = 32;
  localparam int DATA_W    = 16;
  localparam int FLD_W     = 5;
  localparam int PRE_LEN   = 32;
  localparam int FRAME_LEN = PRE_LEN + 4 + 2 * FLD_W + 2 + DATA_W;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam int TA_IDX    = PRE_LEN + 4 + 2 * FLD_W;
  localparam int DATA_IDX  = TA_IDX + 2;

  localparam int PHY_LSB   = 16;
  localparam int REGN_LSB  = 21;
  localparam int OP_BIT    = 26;
  localparam int VALID_BIT = 27;
  localparam int BUSY_BIT  = 28;
  localparam int DONE_BIT  = 4;

  localparam int CMD_OFS   = 'h00;
  localparam int CAUSE_OFS = 'h7C;
  localparam int MASK_OFS  = 'h80;

  typedef struct packed {
    logic              rd;
    logic [FLD_W-1:0]  regad;
    logic [FLD_W-1:0]  phy;
    logic [DATA_W-1:0] data;
  } cmd_t;

  function automatic logic [FRAME_LEN-1:0] build_frame(cmd_t c);
    logic [1:0] op, ta;
    logic [DATA_W-1:0] d;
    op = c.rd ? 2'b10 : 2'b01;
    ta = c.rd ? 2'b11 : 2'b10;
    d  = c.rd ? {DATA_W{1'b1}} : c.data;
    return {{PRE_LEN{1'b1}}, 2'b01, op, c.phy, c.regad, ta, d};
  endfunction
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int CLK_HALF = 4,
  parameter int CNT_W    = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  logic mdc_q;
  logic tick;

  generate
    if (CLK_HALF <= 1) begin : g_fast
      assign tick = run_i;
    end else begin : g_div
      logic [CNT_W-1:0] cnt_q;
      assign tick = run_i && (cnt_q == CNT_W'(CLK_HALF - 1));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     cnt_q <= '0;
        else if (!run_i) cnt_q <= '0;
        else if (tick)   cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     mdc_q <= 1'b0;
    else if (!run_i) mdc_q <= 1'b0;
    else if (tick)   mdc_q <= ~mdc_q;
  end

  assign mdc_o  = mdc_q;
  assign rise_o = tick & ~mdc_q;
  assign fall_o = tick & mdc_q;
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  cmd_t              cmd_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mdio_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic                 busy_q, rd_q;
  logic [IDX_W-1:0]     idx_q;
  logic [FRAME_LEN-1:0] sh_q;
  logic [DATA_W-1:0]    cap_q;
  logic                 last_bit, in_data, released;

  assign last_bit = idx_q == IDX_W'(FRAME_LEN - 1);
  assign in_data  = idx_q >= IDX_W'(DATA_IDX);
  assign released = rd_q && (idx_q >= IDX_W'(TA_IDX));
  assign done_o   = busy_q && fall_i && last_bit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      idx_q  <= '0;
      sh_q   <= '1;
      cap_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      rd_q   <= cmd_i.rd;
      idx_q  <= '0;
      sh_q   <= build_frame(cmd_i);
      cap_q  <= '0;
    end else if (busy_q) begin
      if (rise_i && rd_q && in_data) cap_q <= {cap_q[DATA_W-2:0], mdio_i};
      if (fall_i) begin
        if (last_bit) begin
          busy_q <= 1'b0;
          idx_q  <= '0;
        end else begin
          idx_q <= idx_q + 1'b1;
          sh_q  <= {sh_q[FRAME_LEN-2:0], 1'b1};
        end
      end
    end
  end

  assign busy_o    = busy_q;
  assign mdio_o    = busy_q ? sh_q[FRAME_LEN-1] : 1'b1;
  assign mdio_oe_o = busy_q && !released;
  assign rdata_o   = cap_q;
  assign idx_o     = idx_q;
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [REG_W-1:0]  bus_wdata_i,
  output logic [REG_W-1:0]  bus_rdata_o,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] phy_data_i,
  output logic              start_o,
  output cmd_t              new_cmd_o,
  output cmd_t              cmd_o,
  output logic              rvalid_o,
  output logic              cause_o,
  output logic              mask_o,
  output logic              irq_o
);
  cmd_t cmd_q;
  logic rvalid_q, cause_q, mask_q;
  logic sel_cmd, sel_cause, sel_mask;
  logic unused_wdata;

  assign sel_cmd   = bus_addr_i == ADDR_W'(CMD_OFS);
  assign sel_cause = bus_addr_i == ADDR_W'(CAUSE_OFS);
  assign sel_mask  = bus_addr_i == ADDR_W'(MASK_OFS);

  assign new_cmd_o.rd    = bus_wdata_i[OP_BIT];
  assign new_cmd_o.regad = bus_wdata_i[REGN_LSB +: FLD_W];
  assign new_cmd_o.phy   = bus_wdata_i[PHY_LSB +: FLD_W];
  assign new_cmd_o.data  = bus_wdata_i[DATA_W-1:0];
  assign start_o         = bus_wr_i && sel_cmd && !busy_i;

  assign unused_wdata = ^{bus_wdata_i[REG_W-1:OP_BIT+1], bus_wdata_i[DONE_BIT-1:0],
                          bus_wdata_i[PHY_LSB-1:DONE_BIT+1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q    <= '0;
      rvalid_q <= 1'b0;
    end else if (start_o) begin
      cmd_q    <= new_cmd_o;
      rvalid_q <= 1'b0;
    end else if (done_i && cmd_q.rd) begin
      cmd_q.data <= phy_data_i;
      rvalid_q   <= 1'b1;
    end
  end

  // completion wins over a concurrent clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                          cause_q <= 1'b0;
    else if (done_i)                                      cause_q <= 1'b1;
    else if (bus_wr_i && sel_cause && !bus_wdata_i[DONE_BIT]) cause_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    mask_q <= 1'b0;
    else if (bus_wr_i && sel_mask)  mask_q <= bus_wdata_i[DONE_BIT];
  end

  always_comb begin
    bus_rdata_o = '0;
    if (sel_cmd) begin
      bus_rdata_o[DATA_W-1:0]          = cmd_q.data;
      bus_rdata_o[PHY_LSB +: FLD_W]    = cmd_q.phy;
      bus_rdata_o[REGN_LSB +: FLD_W]   = cmd_q.regad;
      bus_rdata_o[OP_BIT]              = cmd_q.rd;
      bus_rdata_o[VALID_BIT]           = rvalid_q;
      bus_rdata_o[BUSY_BIT]            = busy_i;
    end else if (sel_cause) begin
      bus_rdata_o[DONE_BIT] = cause_q;
    end else if (sel_mask) begin
      bus_rdata_o[DONE_BIT] = mask_q;
    end
  end

  assign cmd_o    = cmd_q;
  assign rvalid_o = rvalid_q;
  assign cause_o  = cause_q;
  assign mask_o   = mask_q;
  assign irq_o    = cause_q & mask_q;
endmodule

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int CLK_HALF = 4,
  parameter int ADDR_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  input  logic              mdio_i,
  output logic              irq_o
);
  localparam int CNT_W = (CLK_HALF > 1) ? $clog2(CLK_HALF) : 1;

  logic              busy, done, start, rise, fall;
  logic              rvalid, cause, mask;
  cmd_t              new_cmd, cmd_q;
  logic [DATA_W-1:0] phy_data;
  logic [IDX_W-1:0]  bit_idx;

  mdio_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bus_wr_i   (bus_wr_i),
    .bus_addr_i (bus_addr_i),
    .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o),
    .busy_i     (busy),
    .done_i     (done),
    .phy_data_i (phy_data),
    .start_o    (start),
    .new_cmd_o  (new_cmd),
    .cmd_o      (cmd_q),
    .rvalid_o   (rvalid),
    .cause_o    (cause),
    .mask_o     (mask),
    .irq_o      (irq_o)
  );

  mdio_clkdiv #(.CLK_HALF(CLK_HALF), .CNT_W(CNT_W)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (busy),
    .mdc_o (mdc_o),
    .rise_o(rise),
    .fall_o(fall)
  );

  mdio_frame u_frame (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .cmd_i    (new_cmd),
    .rise_i   (rise),
    .fall_i   (fall),
    .mdio_i   (mdio_i),
    .busy_o   (busy),
    .done_o   (done),
    .mdio_o   (mdio_o),
    .mdio_oe_o(mdio_oe_o),
    .rdata_o  (phy_data),
    .idx_o    (bit_idx)
  );
endmodule

// File: rtl/mdio_ctrl_chk.sv
module mdio_ctrl_chk
  import mdio_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_wr_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              mdc_o,
  input logic              mdio_o,
  input logic              mdio_oe_o,
  input logic              irq_o,
  input logic              busy,
  input logic              start,
  input logic              done,
  input logic              rvalid,
  input logic              cause,
  input logic              mask,
  input logic [26:0]       cmd_bits,
  input logic [IDX_W-1:0]  bit_idx
);
  logic wr_cmd;
  assign wr_cmd = bus_wr_i && (bus_addr_i == ADDR_W'(CMD_OFS));

  p_mdc_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !mdc_o);

  p_mdio_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mdc_o) && mdc_o) |-> $stable(mdio_o));

  p_release_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && cmd_bits[26] && bit_idx >= IDX_W'(TA_IDX)) |-> !mdio_oe_o);

  p_start_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> busy);

  p_ignore_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && wr_cmd && !done) |=> $stable(cmd_bits));

  p_valid_clr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> !rvalid);

  p_cause_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> cause);

  p_irq_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mask || !cause) |-> !irq_o);
endmodule

bind mdio_ctrl mdio_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .bus_wr_i  (bus_wr_i),
  .bus_addr_i(bus_addr_i),
  .mdc_o     (mdc_o),
  .mdio_o    (mdio_o),
  .mdio_oe_o (mdio_oe_o),
  .irq_o     (irq_o),
  .busy      (busy),
  .start     (start),
  .done      (done),
  .rvalid    (rvalid),
  .cause     (cause),
  .mask      (mask),
  .cmd_bits  (cmd_q),
  .bit_idx   (bit_idx)
);

// File: tb/sim_mdio_ctrl.sv
module sim_mdio_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 2;
  localparam logic [7:0] A_CMD = 8'h00, A_CAUSE = 8'h7C, A_MASK = 8'h80;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic mdio_in = 1'b1;
  logic mdc, mdio_out, mdio_oe, irq;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_ctrl #(.CLK_HALF(HALF), .ADDR_W(8)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .mdc_o(mdc),
    .mdio_o(mdio_out), .mdio_oe_o(mdio_oe), .mdio_i(mdio_in), .irq_o(irq)
  );

  // PHY model
  logic cur_rd = 1'b0;
  logic [15:0] cur_val = '0;
  int rise_cnt = 0, per_err = 0, chg_err = 0;
  logic [63:0] line_h = '0, oe_h = '0;
  time last_rise = 0;
  logic prev_mdio = 1'b1, prev_mdc = 1'b0;

  always @(posedge mdc) begin
    if (rise_cnt > 0 && ($time - last_rise) != time'(2 * HALF * CLK_PERIOD)) per_err++;
    last_rise = $time;
    line_h = {line_h[62:0], mdio_oe ? mdio_out : mdio_in};
    oe_h   = {oe_h[62:0], mdio_oe};
    rise_cnt++;
  end

  always @(negedge mdc) begin
    if (cur_rd && rise_cnt == 47) mdio_in = 1'b0;
    else if (cur_rd && rise_cnt >= 48 && rise_cnt <= 63) mdio_in = cur_val[63 - rise_cnt];
    else mdio_in = 1'b1;
  end

  always @(negedge clk) begin
    if (mdc && prev_mdc && mdio_out != prev_mdio) chg_err++;
    prev_mdio = mdio_out;
    prev_mdc  = mdc;
  end

  function automatic logic [15:0] phy_val(logic [4:0] p, logic [4:0] r);
    return {p, r, 6'h15} ^ 16'h5A3C;
  endfunction

  function automatic logic [31:0] cmd_word(bit rd, logic [4:0] p, logic [4:0] r, logic [15:0] d);
    logic [31:0] w;
    w = {3'b111, 2'b11, rd, r, p, d};  // bits 31:27 must be ignored
    return w;
  endfunction

  function automatic logic [63:0] exp_line(bit rd, logic [4:0] p, logic [4:0] r, logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, p, r, 2'b10, rd ? phy_val(p, r) : d};
  endfunction

  function automatic logic [63:0] exp_oe(bit rd);
    return {{46{1'b1}}, rd ? 18'h0 : 18'h3FFFF};
  endfunction

  task automatic chk(bit ok, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  task automatic bus_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1 bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic begin_txn(bit rd, logic [4:0] p, logic [4:0] r, logic [15:0] d);
    cur_rd = rd; cur_val = phy_val(p, r);
    rise_cnt = 0; per_err = 0;
    bus_write(A_CMD, cmd_word(rd, p, r, d));
  endtask

  task automatic end_txn(bit rd, logic [4:0] p, logic [4:0] r, logic [15:0] d, bit count_busy);
    logic [31:0] v;
    int n;
    logic [15:0] ed;
    ed = rd ? phy_val(p, r) : d;
    n = 0;
    do begin bus_read(A_CMD, v); n++; end while (v[28] && n < 5000);
    if (count_busy) chk(n - 1 == 128 * HALF, "R4 busy length", 64'(n - 1), 64'(128 * HALF));
    chk(v[28] == 1'b0, "R4 busy clears", 64'(v[28]), 64'd0);
    chk(v[27] == rd, "R3 read valid flag", 64'(v[27]), 64'(rd));
    chk(v[15:0] == ed, "R3 data field", 64'(v[15:0]), 64'(ed));
    chk(v[26:16] == {rd, r, p}, "R2 command fields", 64'(v[26:16]), 64'({rd, r, p}));
    chk(v[31:29] == 3'b0, "R10 command high bits", 64'(v[31:29]), 64'd0);
    chk(rise_cnt == 64, "R2 mdc cycles per frame", 64'(rise_cnt), 64'd64);
    chk(line_h == exp_line(rd, p, r, d), "R2 frame bits", line_h, exp_line(rd, p, r, d));
    chk(oe_h == exp_oe(rd), "R3 output enable pattern", oe_h, exp_oe(rd));
    chk(per_err == 0, "R7 mdc period", 64'(per_err), 64'd0);
    chk(!mdc && !mdio_oe, "R7 idle pins", 64'({mdc, mdio_oe}), 64'd0);
    bus_read(A_CAUSE, v);
    chk(v == 32'h10, "R8 cause set on completion", 64'(v), 64'h10);
  endtask

  task automatic full_txn(bit rd, logic [4:0] p, logic [4:0] r, logic [15:0] d);
    begin_txn(rd, p, r, d);
    end_txn(rd, p, r, d, 1'b1);
    bus_write(A_CAUSE, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    bus_read(A_CMD, v);   chk(v == 0, "R1 command reset", 64'(v), 64'd0);
    bus_read(A_CAUSE, v); chk(v == 0, "R1 cause reset", 64'(v), 64'd0);
    bus_read(A_MASK, v);  chk(v == 0, "R1 mask reset", 64'(v), 64'd0);
    chk({irq, mdc, mdio_oe} == 3'b0, "R1 pins reset", 64'({irq, mdc, mdio_oe}), 64'd0);

    // directed write and read frames
    full_txn(1'b0, 5'h1F, 5'h00, 16'hA5C3);
    full_txn(1'b1, 5'h00, 5'h1F, 16'h0000);

    // R6 new command clears valid; R4 busy right after start
    begin_txn(1'b0, 5'h05, 5'h0A, 16'h1234);
    bus_read(A_CMD, v);
    chk(v[27] == 1'b0, "R6 valid cleared by new command", 64'(v[27]), 64'd0);
    chk(v[28] == 1'b1, "R4 busy after start", 64'(v[28]), 64'd1);
    end_txn(1'b0, 5'h05, 5'h0A, 16'h1234, 1'b0);
    bus_write(A_CAUSE, 32'h0);

    // R5 command write while busy is ignored
    begin_txn(1'b0, 5'h03, 5'h07, 16'hBEEF);
    repeat (20) @(posedge clk);
    bus_write(A_CMD, cmd_word(1'b1, 5'h09, 5'h11, 16'h0F0F));
    end_txn(1'b0, 5'h03, 5'h07, 16'hBEEF, 1'b0);
    repeat (300) @(posedge clk);
    chk(rise_cnt == 64, "R5 no extra frame", 64'(rise_cnt), 64'd64);
    bus_read(A_CMD, v);
    chk(v[28:16] == {2'b00, 1'b0, 5'h07, 5'h03}, "R5 fields kept", 64'(v[28:16]),
        64'({2'b00, 1'b0, 5'h07, 5'h03}));
    bus_write(A_CAUSE, 32'h0);

    // R8 keep with bit 4 = 1, clear with 0
    full_txn(1'b1, 5'h12, 5'h04, 16'h0);
    begin_txn(1'b0, 5'h01, 5'h02, 16'h0003);
    end_txn(1'b0, 5'h01, 5'h02, 16'h0003, 1'b1);
    bus_write(A_CAUSE, 32'hFFFF_FFFF);
    bus_read(A_CAUSE, v); chk(v == 32'h10, "R8 write one keeps", 64'(v), 64'h10);
    chk(irq == 1'b0, "R9 masked irq low", 64'(irq), 64'd0);
    bus_write(A_MASK, 32'hFFFF_FFFF);
    bus_read(A_MASK, v);  chk(v == 32'h10, "R10 mask other bits", 64'(v), 64'h10);
    #1 chk(irq == 1'b1, "R9 irq when cause and mask", 64'(irq), 64'd1);
    bus_write(A_CAUSE, 32'hFFFF_FFEF);
    bus_read(A_CAUSE, v); chk(v == 32'h0, "R8 write zero clears", 64'(v), 64'd0);
    chk(irq == 1'b0, "R9 irq drops on clear", 64'(irq), 64'd0);

    // R8 completion and clear on the same edge: set wins
    begin_txn(1'b0, 5'h0C, 5'h15, 16'h7E81);
    repeat (128 * HALF - 1) @(posedge clk);
    bus_write(A_CAUSE, 32'h0);
    end_txn(1'b0, 5'h0C, 5'h15, 16'h7E81, 1'b0);
    chk(irq == 1'b1, "R9 irq after collision", 64'(irq), 64'd1);
    bus_write(A_CAUSE, 32'h0);
    bus_read(A_CAUSE, v); chk(v == 32'h0, "R8 clear after collision", 64'(v), 64'd0);
    bus_write(A_MASK, 32'h0);

    // random frames
    for (int i = 0; i < 14; i++) begin
      logic [31:0] rnd;
      rnd = $urandom();
      full_txn(rnd[31], rnd[4:0], rnd[9:5], rnd[25:10]);
    end

    chk(chg_err == 0, "R7 mdio stable while mdc high", 64'(chg_err), 64'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule